// File: doc/BRIEF.md
# I2C Target Transmit Preload Controller

This block is the transmit-side control of an I2C target. The bit-level bus engine hands it abstracted events: an address match with its direction, and a strobe each time a data byte has been shifted out. The block answers every address match with an acknowledge decision and supplies the byte to be shifted next. Software fills a transmit FIFO ahead of time through a write port. It configures the block through a small control word: preload enable, a ready bit, and two "keep" bits that stop the FIFO from being emptied on a read match or on a write match.

With preload enabled, a read request from the master is refused (NACK) until software has filled the FIFO and raised the ready bit. The first byte sent after an accepted read drops the ready bit again, so software must arm each read on its own. Every FIFO flush caused by an address match sets a lockout flag. While that flag is set, software writes to the FIFO are discarded. Software clears the flag with a write-one-to-clear pulse.

Top module: `i2c_tgt_preload_ctrl`

## Requirements
- R1: After a synchronous reset, the ready, preload and lockout flags read 0, the FIFO level is 0, resp_valid is 0 and tx_data is all ones.
- R2: With preload enabled and ready at 0, a read address match is answered one cycle later with resp_valid=1 and resp_ack=0. No byte is taken from the FIFO.
- R3: With preload enabled and ready at 1, a read address match is answered with resp_ack=1, and tx_data shows the oldest FIFO byte. The FIFO level drops by one.
- R4: During an accepted read, each byte_done pulse loads the next FIFO byte into tx_data in write order. The first such pulse clears the ready flag.
- R5: A control write that turns preload from 0 to 1 leaves ready at 0, even if the written ready value is 1.
- R6: If a control write sets ready in the same cycle as a byte_done pulse clears it, ready ends at 0.
- R7: Every address-match flush sets the lockout flag. While the flag is set, FIFO writes are dropped and the level stays unchanged. A lock_clr pulse clears the flag.
- R8: A read address match empties the FIFO (level 0) unless rd_keep is 1. A flushed accepted read sends all ones.
- R9: A write address match is always acknowledged. It empties the FIFO unless wr_keep is 1.
- R10: When the FIFO is empty during an accepted read, tx_data is all ones for every further byte.
- R11: With preload disabled, every read address match is acknowledged, whatever the ready value.
- R12: FIFO writes beyond DEPTH entries are dropped, and fifo_level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_preload | input | 1 | Written preload enable |
| ctl_ready | input | 1 | Written ready value |
| ctl_rd_keep | input | 1 | Written: do not flush on read match |
| ctl_wr_keep | input | 1 | Written: do not flush on write match |
| lock_clr | input | 1 | Write-one-to-clear pulse for lockout |
| fifo_we | input | 1 | FIFO write strobe |
| fifo_wdata | input | DATA_W | FIFO write byte |
| am_valid | input | 1 | Address match strobe |
| am_read | input | 1 | Match direction, 1 = master reads |
| byte_done | input | 1 | Current transmit byte has been sent |
| resp_valid | output | 1 | Acknowledge decision valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_data | output | DATA_W | Byte to be transmitted next |
| st_preload | output | 1 | Preload enable state |
| st_ready | output | 1 | Ready flag state |
| st_lock | output | 1 | Lockout flag state |
| fifo_level | output | $clog2(DEPTH)+1 | FIFO occupancy |

## Verification
Every result of this block is registered once. The acknowledge decision, tx_data, FIFO level, ready and lockout all change at the first rising edge after the stimulus is sampled, and resp_valid stays high for exactly that one cycle. The bench drives each stimulus at a falling edge and holds it for one cycle. It reads the outputs at the following falling edge, half a period after they were due and before the next stimulus can touch them.

// File: rtl/i2c_pre_pkg.sv
package i2c_pre_pkg;
  typedef struct packed {
    logic preload;
    logic ready;
    logic rd_keep;
    logic wr_keep;
  } pre_ctl_t;
endpackage

// File: rtl/pre_fifo.sv
module pre_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              lock,
  input  logic              fetch,
  input  logic              flush,
  output logic [DATA_W-1:0] q,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b1}};
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic empty, full, do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == FULL_LVL);
  assign do_push = push_req && !lock && !full && !flush;
  assign do_pop  = fetch && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      q     <= FILL;
    end else begin
      if (fetch) q <= (flush || empty) ? FILL : mem[rp];
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        level <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> level == '0);
  // R7
  lock_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && lock && !fetch && !flush) |=> level == $past(level));
endmodule

// File: rtl/pre_ctl_regs.sv
module pre_ctl_regs
  import i2c_pre_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  pre_ctl_t wd,
  input  logic     hw_clr,
  input  logic     flush,
  input  logic     lock_clr,
  output pre_ctl_t cfg,
  output logic     lock
);
  logic arm_rise;
  assign arm_rise = we && wd.preload && !cfg.preload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      lock <= 1'b0;
    end else begin
      if (we) begin
        cfg.preload <= wd.preload;
        cfg.rd_keep <= wd.rd_keep;
        cfg.wr_keep <= wd.wr_keep;
      end
      if (hw_clr)        cfg.ready <= 1'b0;
      else if (arm_rise) cfg.ready <= 1'b0;
      else if (we)       cfg.ready <= wd.ready;
      if (flush)         lock <= 1'b1;
      else if (lock_clr) lock <= 1'b0;
    end
  end

  // R6
  hw_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hw_clr |=> !cfg.ready);
  // R5
  preload_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wd.preload && !cfg.preload) |=> !cfg.ready);
  // R7
  lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> lock);
endmodule

// File: rtl/pre_responder.sv
module pre_responder (
  input  logic clk,
  input  logic rst,
  input  logic am_valid,
  input  logic am_read,
  input  logic byte_done,
  input  logic preload,
  input  logic ready,
  input  logic rd_keep,
  input  logic wr_keep,
  output logic resp_valid,
  output logic resp_ack,
  output logic fetch,
  output logic flush,
  output logic hw_clr
);
  logic rd_active, rd_accept;

  assign rd_accept = !preload || ready;
  assign flush  = am_valid && (am_read ? !rd_keep : !wr_keep);
  assign hw_clr = byte_done && rd_active && !am_valid;
  assign fetch  = (am_valid && am_read && rd_accept) || hw_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      rd_active  <= 1'b0;
    end else begin
      resp_valid <= am_valid;
      if (am_valid) begin
        resp_ack  <= am_read ? rd_accept : 1'b1;
        rd_active <= am_read && rd_accept;
      end
    end
  end

  // R2
  nack_unready_chk: assert property (@(posedge clk) disable iff (rst)
    (am_valid && am_read && preload && !ready) |=> (resp_valid && !resp_ack));
  // R11
  plain_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (am_valid && am_read && !preload) |=> resp_ack);
  // R9
  write_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (am_valid && !am_read) |=> (resp_valid && resp_ack));
endmodule

// File: rtl/i2c_tgt_preload_ctrl.sv
module i2c_tgt_preload_ctrl
  import i2c_pre_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_we,
  input  logic                    ctl_preload,
  input  logic                    ctl_ready,
  input  logic                    ctl_rd_keep,
  input  logic                    ctl_wr_keep,
  input  logic                    lock_clr,
  input  logic                    fifo_we,
  input  logic [DATA_W-1:0]       fifo_wdata,
  input  logic                    am_valid,
  input  logic                    am_read,
  input  logic                    byte_done,
  output logic                    resp_valid,
  output logic                    resp_ack,
  output logic [DATA_W-1:0]       tx_data,
  output logic                    st_preload,
  output logic                    st_ready,
  output logic                    st_lock,
  output logic [$clog2(DEPTH):0]  fifo_level
);
  pre_ctl_t wd, cfg;
  logic fetch, flush, hw_clr, lock;

  assign wd = '{preload: ctl_preload, ready: ctl_ready,
                rd_keep: ctl_rd_keep, wr_keep: ctl_wr_keep};

  pre_ctl_regs u_regs (
    .clk(clk), .rst(rst), .we(ctl_we), .wd(wd), .hw_clr(hw_clr),
    .flush(flush), .lock_clr(lock_clr), .cfg(cfg), .lock(lock)
  );

  pre_responder u_resp (
    .clk(clk), .rst(rst), .am_valid(am_valid), .am_read(am_read),
    .byte_done(byte_done), .preload(cfg.preload), .ready(cfg.ready),
    .rd_keep(cfg.rd_keep), .wr_keep(cfg.wr_keep),
    .resp_valid(resp_valid), .resp_ack(resp_ack),
    .fetch(fetch), .flush(flush), .hw_clr(hw_clr)
  );

  pre_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_req(fifo_we), .push_data(fifo_wdata),
    .lock(lock), .fetch(fetch), .flush(flush), .q(tx_data), .level(fifo_level)
  );

  assign st_preload = cfg.preload;
  assign st_ready   = cfg.ready;
  assign st_lock    = lock;
endmodule

// File: tb/i2c_tgt_preload_ctrl_test.sv
module i2c_tgt_preload_ctrl_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1;
  logic ctl_we = 0, ctl_preload = 0, ctl_ready = 0, ctl_rd_keep = 0, ctl_wr_keep = 0;
  logic lock_clr = 0, fifo_we = 0, am_valid = 0, am_read = 0, byte_done = 0;
  logic [DW-1:0] fifo_wdata = '0;
  logic resp_valid, resp_ack, st_preload, st_ready, st_lock;
  logic [DW-1:0] tx_data;
  logic [LW-1:0] fifo_level;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  i2c_tgt_preload_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_preload(ctl_preload),
    .ctl_ready(ctl_ready), .ctl_rd_keep(ctl_rd_keep), .ctl_wr_keep(ctl_wr_keep),
    .lock_clr(lock_clr), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .am_valid(am_valid), .am_read(am_read), .byte_done(byte_done),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .tx_data(tx_data),
    .st_preload(st_preload), .st_ready(st_ready), .st_lock(st_lock),
    .fifo_level(fifo_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic pre, input logic rdy, input logic rk, input logic wk);
    @(negedge clk);
    ctl_we = 1; ctl_preload = pre; ctl_ready = rdy; ctl_rd_keep = rk; ctl_wr_keep = wk;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic push(input logic [DW-1:0] b);
    @(negedge clk);
    fifo_we = 1; fifo_wdata = b;
    @(negedge clk);
    fifo_we = 0;
  endtask

  task automatic match(input logic rd);
    @(negedge clk);
    am_valid = 1; am_read = rd;
    @(negedge clk);
    am_valid = 0;
  endtask

  task automatic sent();
    @(negedge clk);
    byte_done = 1;
    @(negedge clk);
    byte_done = 0;
  endtask

  task automatic unlock();
    @(negedge clk);
    lock_clr = 1;
    @(negedge clk);
    lock_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready", st_ready, 0);
    chk("R1 preload", st_preload, 0);
    chk("R1 lock", st_lock, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 tx_data", tx_data, 8'hFF);
  endtask

  task automatic t_nack_unready();
    cfg(1, 0, 1, 1);
    push(8'hA1); push(8'hA2);
    match(1);
    chk("R2 resp_valid", resp_valid, 1);
    chk("R2 resp_ack", resp_ack, 0);
    chk("R2 level kept", fifo_level, 2);
  endtask

  task automatic t_ack_ready();
    cfg(1, 1, 1, 1);
    chk("R3 ready armed", st_ready, 1);
    match(1);
    chk("R3 resp_ack", resp_ack, 1);
    chk("R3 first byte", tx_data, 8'hA1);
    chk("R3 level", fifo_level, 1);
    sent();
    chk("R4 second byte", tx_data, 8'hA2);
    chk("R4 ready cleared", st_ready, 0);
    sent();
    chk("R10 empty fill", tx_data, 8'hFF);
    sent();
    chk("R10 empty fill again", tx_data, 8'hFF);
    match(1);
    chk("R4 next read refused", resp_ack, 0);
  endtask

  task automatic t_preload_rise();
    cfg(0, 0, 1, 1);
    cfg(1, 1, 1, 1);
    chk("R5 rise forces ready 0", st_ready, 0);
    chk("R5 preload on", st_preload, 1);
    cfg(1, 1, 1, 1);
    chk("R5 later write arms", st_ready, 1);
  endtask

  task automatic t_collision();
    push(8'hB1);
    match(1);
    chk("R3 ack", resp_ack, 1);
    chk("R3 byte", tx_data, 8'hB1);
    @(negedge clk);
    byte_done = 1; ctl_we = 1; ctl_preload = 1; ctl_ready = 1; ctl_rd_keep = 1; ctl_wr_keep = 1;
    @(negedge clk);
    byte_done = 0; ctl_we = 0;
    chk("R6 hw clear wins", st_ready, 0);
    chk("R10 fill after last", tx_data, 8'hFF);
  endtask

  task automatic t_read_flush();
    cfg(1, 1, 0, 1);
    push(8'hC1); push(8'hC2);
    chk("R8 level before", fifo_level, 2);
    match(1);
    chk("R8 ack", resp_ack, 1);
    chk("R8 flushed byte", tx_data, 8'hFF);
    chk("R8 level flushed", fifo_level, 0);
    chk("R7 lock set", st_lock, 1);
    push(8'hD1);
    chk("R7 write dropped", fifo_level, 0);
    unlock();
    chk("R7 lock cleared", st_lock, 0);
    push(8'hD1);
    chk("R7 write accepted", fifo_level, 1);
  endtask

  task automatic t_write_flush();
    cfg(1, 0, 1, 0);
    match(0);
    chk("R9 write ack", resp_ack, 1);
    chk("R9 level flushed", fifo_level, 0);
    chk("R7 lock on write flush", st_lock, 1);
    unlock();
    cfg(1, 0, 1, 1);
    push(8'hE1);
    match(0);
    chk("R9 write ack kept", resp_ack, 1);
    chk("R9 level kept", fifo_level, 1);
    chk("R9 no lock", st_lock, 0);
  endtask

  task automatic t_preload_off();
    cfg(0, 0, 1, 1);
    match(1);
    chk("R11 ack without ready", resp_ack, 1);
    chk("R11 byte", tx_data, 8'hE1);
    chk("R11 level", fifo_level, 0);
  endtask

  task automatic t_full();
    match(0);
    for (int i = 0; i < DEPTH + 2; i++) push(DW'(8'h10 + i));
    chk("R12 level capped", fifo_level, DEPTH);
    match(1);
    chk("R12 oldest kept", tx_data, 8'h10);
    chk("R12 level after read", fifo_level, DEPTH - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_nack_unready();
    t_ack_ready();
    t_preload_rise();
    t_collision();
    t_read_flush();
    t_write_flush();
    t_preload_off();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule